// File: doc/BRIEF.md
# Two-Word Add-and-Rotate Pseudo-Random Generator

The block holds 128 bits of generator state as two 64-bit words and, on each step request, emits a 64-bit random word derived from the sum of the two words. In the same cycle it advances the state with a xor, shift and rotate update. The sum is formed at full precision, with the carry out of the add kept as a 65th bit. An output mapping input selects what the sum turns into. The default is the plain low 64 bits. The other choices are a 63-bit word that drops the weak least significant bit, or a word that drops bit 0 and takes the carry in at the top. The carry-including word is known to perform poorly under statistical test batteries, so it exists for experiments only.

Software or a host block seeds the generator through a two-word load port. The all-zero state is a fixed point of the update and is rejected: loading it installs a safe state and raises an error flag. A synchronous reset installs the same safe state.

Top module: `prng_x128p`

## Requirements
- R1: After reset the state is word A = 1 and word B = 0, `rnd_valid` is 0, `rnd_out` is 0 and `seed_err` is 0. The first step after reset in full mode therefore yields 1.
- R2: `rnd_valid` is 1 in exactly the cycle after an edge at which `step_en` was 1 and `seed_load` was 0. In every other cycle it is 0.
- R3: With `out_mode` = 2'b00, and also with the unused code 2'b11, `rnd_out` is the low 64 bits of A + B, taken from the state before the step.
- R4: With `out_mode` = 2'b01, `rnd_out` is {1'b0, sum[63:1]}, where sum is the 65-bit value A + B.
- R5: With `out_mode` = 2'b10, `rnd_out` is sum[64:1]. The carry out of the 64-bit add appears in output bit 63.
- R6: A step replaces the state as follows, with t = A ^ B: the new A is rotl(A,55) ^ t ^ (t << 14), and the new B is rotl(t,36).
- R7: `seed_load` writes `seed_a` into A and `seed_b` into B, clears `seed_err` for a non-zero seed, and takes priority over `step_en` in the same cycle: no step occurs and no output is produced.
- R8: Loading A = B = 0 installs A = 1, B = 0 and sets `seed_err`. The flag stays set until the next load or reset.
- R9: In a cycle with no step, `rnd_out` holds its value and the state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load the seed words this cycle |
| seed_a | input | 64 | Seed for state word A |
| seed_b | input | 64 | Seed for state word B |
| step_en | input | 1 | Produce one output word and advance the state |
| out_mode | input | 2 | Output mapping: 00 full sum, 01 sum[63:1] with a zero at the top, 10 sum[64:1], 11 same as 00 |
| rnd_out | output | 64 | Registered random word |
| rnd_valid | output | 1 | `rnd_out` was updated at the last edge |
| seed_err | output | 1 | The last seed was all zero and was replaced |

## Verification
On every cycle the assertions check:
- the valid timing;
- that the output holds while no step occurs;
- that the state never reaches all zero;
- how the error flag responds to zero and non-zero seeds;
- that the 63-bit mapping always has a zero at the top;
- that a load wins over a step.

The exact output words, the carry placement under the carry mapping, and the correctness of the state update over long runs can only be shown by the bench. The bench sweeps several hundred steps through all four mode codes from several seeds and compares each word against an arithmetic model of the sum and update.

// File: rtl/prng_x128p_pkg.sv
`timescale 1ns/1ps
package prng_x128p_pkg;
  localparam int unsigned WORD_BITS = 64;

  typedef enum logic [1:0] {
    MAP_FULL   = 2'b00,
    MAP_DROP0  = 2'b01,
    MAP_CARRY  = 2'b10,
    MAP_SPARE  = 2'b11
  } out_map_e;
endpackage

// File: rtl/xr_next_state.sv
`timescale 1ns/1ps
module xr_next_state #(
  parameter int unsigned W   = 64,
  parameter int unsigned ROT_A = 55,
  parameter int unsigned SHL_B = 14,
  parameter int unsigned ROT_C = 36
) (
  input  logic [W-1:0] cur_a,
  input  logic [W-1:0] cur_b,
  output logic [W-1:0] nxt_a,
  output logic [W-1:0] nxt_b
);
  logic [W-1:0] mix;
  logic [W-1:0] rot_a;
  logic [W-1:0] rot_mix;

  always_comb begin
    mix     = cur_a ^ cur_b;
    rot_a   = (cur_a << ROT_A) | (cur_a >> (W - ROT_A));
    rot_mix = (mix << ROT_C) | (mix >> (W - ROT_C));
    nxt_a   = rot_a ^ mix ^ (mix << SHL_B);
    nxt_b   = rot_mix;
  end
endmodule

// File: rtl/xr_out_map.sv
`timescale 1ns/1ps
module xr_out_map
  import prng_x128p_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [1:0]   map_sel,
  output logic [W-1:0] mapped
);
  logic [W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, word_a} + {1'b0, word_b};
    case (out_map_e'(map_sel))
      MAP_DROP0: mapped = {1'b0, wide_sum[W-1:1]};
      MAP_CARRY: mapped = wide_sum[W:1];
      default:   mapped = wide_sum[W-1:0];
    endcase
  end
endmodule

// File: rtl/xr_state_reg.sv
`timescale 1ns/1ps
module xr_state_reg #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] SAFE_A = 1,
  parameter logic [W-1:0] SAFE_B = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_a,
  input  logic [W-1:0] load_b,
  input  logic         advance,
  input  logic [W-1:0] nxt_a,
  input  logic [W-1:0] nxt_b,
  output logic [W-1:0] st_a,
  output logic [W-1:0] st_b,
  output logic         zero_seen
);
  logic seed_is_zero;
  assign seed_is_zero = ~|{load_a, load_b};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_a      <= SAFE_A;
      st_b      <= SAFE_B;
      zero_seen <= 1'b0;
    end else if (load) begin
      zero_seen <= seed_is_zero;
      if (seed_is_zero) begin
        st_a <= SAFE_A;
        st_b <= SAFE_B;
      end else begin
        st_a <= load_a;
        st_b <= load_b;
      end
    end else if (advance) begin
      st_a <= nxt_a;
      st_b <= nxt_b;
    end
  end
endmodule

// File: rtl/prng_x128p.sv
`timescale 1ns/1ps
module prng_x128p
  import prng_x128p_pkg::*;
#(
  parameter int unsigned W     = WORD_BITS,
  parameter int unsigned ROT_A = 55,
  parameter int unsigned SHL_B = 14,
  parameter int unsigned ROT_C = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_load,
  input  logic [63:0]  seed_a,
  input  logic [63:0]  seed_b,
  input  logic         step_en,
  input  logic [1:0]   out_mode,
  output logic [63:0]  rnd_out,
  output logic         rnd_valid,
  output logic         seed_err
);
  localparam logic [W-1:0] SAFE_A = W'(1);
  localparam logic [W-1:0] SAFE_B = '0;

  logic [W-1:0] s0_q, s1_q;
  logic [W-1:0] n0, n1;
  logic [W-1:0] mapped;
  logic         do_step;

  assign do_step = step_en & ~seed_load;

  xr_state_reg #(.W(W), .SAFE_A(SAFE_A), .SAFE_B(SAFE_B)) u_state (
    .clk(clk), .rst(rst), .load(seed_load), .load_a(seed_a), .load_b(seed_b),
    .advance(do_step), .nxt_a(n0), .nxt_b(n1),
    .st_a(s0_q), .st_b(s1_q), .zero_seen(seed_err)
  );

  xr_next_state #(.W(W), .ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C)) u_next (
    .cur_a(s0_q), .cur_b(s1_q), .nxt_a(n0), .nxt_b(n1)
  );

  xr_out_map #(.W(W)) u_map (
    .word_a(s0_q), .word_b(s1_q), .map_sel(out_mode), .mapped(mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_out   <= '0;
      rnd_valid <= 1'b0;
    end else begin
      rnd_valid <= do_step;
      if (do_step) rnd_out <= mapped;
    end
  end
endmodule

// File: rtl/prng_x128p_chk.sv
`timescale 1ns/1ps
module prng_x128p_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         seed_load,
  input logic [63:0]  seed_a,
  input logic [63:0]  seed_b,
  input logic         step_en,
  input logic [1:0]   out_mode,
  input logic [63:0]  rnd_out,
  input logic         rnd_valid,
  input logic         seed_err,
  input logic [W-1:0] s0_q,
  input logic [W-1:0] s1_q
);
  // R2
  valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load) |=> rnd_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_en && !seed_load) |=> !rnd_valid);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_en && !seed_load) |=> $stable(rnd_out));
  // R8
  state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (s0_q | s1_q) != '0);
  // R8
  zero_seed_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && seed_a == '0 && seed_b == '0) |=> (seed_err && s0_q == W'(1)));
  // R7
  seed_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && (seed_a | seed_b) != '0) |=>
      (!seed_err && s0_q == $past(seed_a) && s1_q == $past(seed_b)));
  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && step_en) |=> !rnd_valid);
  // R4
  drop0_top_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_load && out_mode == 2'b01) |=> !rnd_out[63]);
endmodule

bind prng_x128p prng_x128p_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .seed_a(seed_a), .seed_b(seed_b),
  .step_en(step_en), .out_mode(out_mode), .rnd_out(rnd_out), .rnd_valid(rnd_valid),
  .seed_err(seed_err), .s0_q(s0_q), .s1_q(s1_q)
);

// File: tb/prng_x128p_test.sv
`timescale 1ns/1ps
module prng_x128p_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seed_load = 1'b0;
  logic [63:0] seed_a = '0, seed_b = '0;
  logic        step_en = 1'b0;
  logic [1:0]  out_mode = 2'b00;
  logic [63:0] rnd_out;
  logic        rnd_valid, seed_err;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [63:0] ma, mb;

  always #5 clk = ~clk;

  prng_x128p uut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_a(seed_a), .seed_b(seed_b),
    .step_en(step_en), .out_mode(out_mode), .rnd_out(rnd_out),
    .rnd_valid(rnd_valid), .seed_err(seed_err)
  );

  function automatic logic [63:0] rotl(input logic [63:0] x, input int k);
    return (x << k) | (x >> (64 - k));
  endfunction

  function automatic logic [63:0] expect_word(input logic [63:0] a, input logic [63:0] b,
                                              input logic [1:0] m);
    logic [64:0] s;
    s = {1'b0, a} + {1'b0, b};
    case (m)
      2'b01:   return s[64:1] & 64'h7FFF_FFFF_FFFF_FFFF;
      2'b10:   return s[64:1];
      default: return s[63:0];
    endcase
  endfunction

  task automatic model_step();
    logic [63:0] t;
    t  = ma ^ mb;
    ma = rotl(ma, 55) ^ t ^ (t << 14);
    mb = rotl(t, 36);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_once(input logic [1:0] m);
    out_mode = m;
    step_en  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_en  = 1'b0;
  endtask

  task automatic load_seed(input logic [63:0] a, input logic [63:0] b, input logic also_step);
    seed_a = a; seed_b = b; seed_load = 1'b1; step_en = also_step;
    @(posedge clk);
    @(negedge clk);
    seed_load = 1'b0; step_en = 1'b0;
  endtask

  task automatic sweep(input int n);
    logic [63:0] held;
    for (int i = 0; i < n; i++) begin
      logic [1:0] m;
      logic [63:0] e;
      m = 2'(i % 4);
      e = expect_word(ma, mb, m);
      step_once(m);
      model_step();
      chk("R3/R4/R5/R6 sweep word", rnd_out, e);
      chk("R2 valid after step", 64'(rnd_valid), 64'd1);
      if (i % 7 == 3) begin
        held = rnd_out;
        @(posedge clk);
        @(negedge clk);
        chk("R9 output holds when idle", rnd_out, held);
        chk("R2 valid low when idle", 64'(rnd_valid), 64'd0);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset out", rnd_out, 64'd0);
    chk("R1 reset valid", 64'(rnd_valid), 64'd0);
    chk("R1 reset seed_err", 64'(seed_err), 64'd0);
    ma = 64'd1; mb = 64'd0;
    step_once(2'b00);
    chk("R1 first word from default seed", rnd_out, 64'd1);
    model_step();
    sweep(600);

    // R5 carry lands in bit 63; R7 seed load
    load_seed('1, '1, 1'b0);
    chk("R7 seed_err clear on nonzero seed", 64'(seed_err), 64'd0);
    chk("R7 no output on load", 64'(rnd_valid), 64'd0);
    ma = '1; mb = '1;
    step_once(2'b10);
    chk("R5 carry mapping all ones", rnd_out, 64'hFFFF_FFFF_FFFF_FFFF);
    model_step();
    load_seed('1, '1, 1'b0);
    ma = '1; mb = '1;
    step_once(2'b01);
    chk("R4 drop-bit-0 mapping", rnd_out, 64'h7FFF_FFFF_FFFF_FFFF);
    model_step();
    load_seed('1, '1, 1'b0);
    ma = '1; mb = '1;
    step_once(2'b00);
    chk("R3 full mapping wraps", rnd_out, 64'hFFFF_FFFF_FFFF_FFFE);
    model_step();
    step_once(2'b11);
    chk("R3 spare code acts as full", rnd_out, expect_word(ma, mb, 2'b00));
    model_step();
    sweep(150);

    // R8 zero seed
    load_seed('0, '0, 1'b0);
    chk("R8 zero seed raises flag", 64'(seed_err), 64'd1);
    ma = 64'd1; mb = 64'd0;
    step_once(2'b00);
    chk("R8 substitute state gives 1", rnd_out, 64'd1);
    chk("R8 flag sticks across steps", 64'(seed_err), 64'd1);
    model_step();
    sweep(50);

    // R7 load beats step
    load_seed(64'd5, 64'd9, 1'b1);
    chk("R7 load clears flag", 64'(seed_err), 64'd0);
    chk("R7 load wins over step", 64'(rnd_valid), 64'd0);
    ma = 64'd5; mb = 64'd9;
    step_once(2'b00);
    chk("R7 loaded seed used unadvanced", rnd_out, 64'd14);
    model_step();
    load_seed(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0003, 1'b0);
    ma = 64'h8000_0000_0000_0001; mb = 64'h8000_0000_0000_0003;
    sweep(200);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule